// File: doc/BRIEF.md
# Instruction Prefetch Byte Queue

This block sits between a processor's bus interface and its execution unit. Whenever the queue has enough free room for a whole bus word, it issues a read for the next sequential instruction address and stores the returned bytes. Fetching goes on while the execution side consumes bytes, so opcode bytes are usually already waiting when they are needed. The execution side takes one byte per pop, always in ascending address order.

A flush request carries a new target address, as it would on a taken branch or jump. The flush empties the queue at once, and fetching restarts at the target. The bus is one or two bytes wide, set by parameter. On a two-byte bus every read is word aligned. If the target is odd, the first read covers the aligned word and only its upper byte is kept. When a read is still outstanding at the time of a flush, the read runs to completion on the bus and its data is thrown away.

The fetch controller has three states. IDLE means no read is outstanding. FETCH means a read for the queue is on the bus. DISCARD means a read is finishing whose data will be dropped. The transitions are:
- IDLE goes to FETCH on a flush, or when there is room for a word.
- FETCH goes to IDLE on an acknowledge.
- FETCH goes to DISCARD on a flush with no acknowledge.
- FETCH stays in FETCH on a flush that arrives together with an acknowledge, and moves to the target.
- DISCARD goes to FETCH when the acknowledge arrives, and the pending target is then issued.

Top module: `prefetch_queue`

## Requirements
- R1: The queue holds at most 6 bytes when BUS_BYTES is 2 and at most 4 bytes when BUS_BYTES is 1. With no pops it fills to exactly that capacity and then stops requesting.
- R2: Once `mem_req` is raised, it stays high with `mem_addr` unchanged until the cycle in which `mem_ack` is high. That cycle completes the read.
- R3: A new read starts only when the free space is at least BUS_BYTES bytes.
- R4: After a completed read with no flush, the next read address is the previous one plus BUS_BYTES. On a two-byte bus, `mem_addr` is always even. Byte lane k of `mem_rdata` (bits 8k+7..8k) holds the byte at `mem_addr`+k.
- R5: `byte_data` presents the queued bytes in strictly ascending address order, with no gaps.
- R6: When the queue is empty, `byte_valid` is low, and a `pop` in that state has no effect.
- R7: A `flush` empties the queue, so `byte_valid` is low in the next cycle. Fetching resumes at the aligned target address.
- R8: On a two-byte bus with an odd target, the first read of the target keeps only the upper byte. The first byte presented is therefore the byte at the target address.
- R9: If a read is outstanding when a flush arrives, the read stays on the bus at its old address until it is acknowledged. Its data is discarded, and the target is fetched next.
- R10: A `flush` takes priority over a `pop` or `mem_ack` in the same cycle. Neither of those changes what the queue holds after the flush.
- R11: Reading continues while bytes are being popped. A continuous stream of pops gets every following address in order.
- R12: After reset, `byte_valid` is low and the first read is at RESET_ADDR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Discard the queue and restart at `flush_addr` |
| flush_addr | input | ADDR_W | Byte address of the branch target |
| mem_req | output | 1 | Read request to memory |
| mem_addr | output | ADDR_W | Read address (aligned to BUS_BYTES) |
| mem_ack | input | 1 | Read completes, data valid this cycle |
| mem_rdata | input | 8*BUS_BYTES | Read data, lane k holds byte at address+k |
| byte_valid | output | 1 | Queue holds at least one byte |
| byte_data | output | 8 | Oldest queued byte |
| pop | input | 1 | Consume the presented byte |

## Verification
Some rules are checked by assertions in every cycle:
- the fill level never passes capacity;
- a read request is held steady until it is acknowledged;
- a new read starts only when there is room for it;
- bus addresses are aligned;
- a flush leaves the queue empty;
- a pop on an empty queue leaves it empty.

Other behaviour only the directed scenarios can show, because it depends on the byte values that come out:
- strict address order across many reads;
- the dropped lower byte on an odd target;
- the discarded data of a read that was outstanding during a flush;
- the exact capacity of six bytes.

// File: rtl/pq_pkg.sv
package pq_pkg;
    typedef enum logic [1:0] {
        FS_IDLE    = 2'd0,
        FS_FETCH   = 2'd1,
        FS_DISCARD = 2'd2
    } fetch_state_t;
endpackage

// File: rtl/pq_store.sv
module pq_store #(
    parameter int DEPTH = 6,
    parameter int LANES = 2,
    parameter int CNT_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               push,
    input  logic [1:0]         push_cnt,
    input  logic [8*LANES-1:0] push_data,
    input  logic               pop,
    output logic [CNT_W-1:0]   level,
    output logic [7:0]         head,
    output logic               valid
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [7:0]       slots [DEPTH];
    logic [PTR_W-1:0] rd_ptr, wr_ptr;
    logic             pop_fire;
    logic [CNT_W-1:0] add_cnt;

    function automatic logic [PTR_W-1:0] wrap(input int v);
        return PTR_W'(v % DEPTH);
    endfunction

    assign valid    = (level != '0);
    assign head     = slots[rd_ptr];
    assign pop_fire = pop && valid && !clear;
    assign add_cnt  = push ? CNT_W'(push_cnt) : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            level  <= '0;
            for (int i = 0; i < DEPTH; i++) slots[i] <= '0;
        end else if (clear) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            level  <= '0;
        end else begin
            for (int i = 0; i < LANES; i++) begin
                if (push && i < int'(push_cnt))
                    slots[wrap(int'(wr_ptr) + i)] <= push_data[8*i +: 8];
            end
            if (push)     wr_ptr <= wrap(int'(wr_ptr) + int'(push_cnt));
            if (pop_fire) rd_ptr <= wrap(int'(rd_ptr) + 1);
            level <= level + add_cnt - CNT_W'(pop_fire);
        end
    end

    // R1: fill level never exceeds capacity
    a_r1_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        int'(level) <= DEPTH);

    // R6: a pop on an empty queue, with nothing arriving, leaves it empty
    a_r6_empty_pop_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid && pop && !push) |=> !valid);
endmodule

// File: rtl/pq_fetch_ctl.sv
module pq_fetch_ctl
    import pq_pkg::*;
#(
    parameter int                BUS_BYTES  = 2,
    parameter int                ADDR_W     = 20,
    parameter int                DEPTH      = 6,
    parameter int                CNT_W      = 3,
    parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic [ADDR_W-1:0] flush_addr,
    input  logic              mem_ack,
    input  logic [CNT_W-1:0]  level,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              take,
    output logic              skip_low
);
    localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'(BUS_BYTES - 1);
    localparam logic [ADDR_W-1:0] STEP     = ADDR_W'(BUS_BYTES);

    fetch_state_t      state, state_nx;
    logic [ADDR_W-1:0] cur_addr, pend_addr, tgt_addr;
    logic              cur_skip, pend_skip, tgt_skip, has_room;

    assign tgt_addr = flush_addr & ~LOW_MASK;
    assign tgt_skip = (BUS_BYTES == 2) && flush_addr[0];
    assign has_room = (CNT_W'(DEPTH) - level) >= CNT_W'(BUS_BYTES);

    always_ff @(posedge clk) begin
        if (!rst_n) state <= FS_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            FS_IDLE:    if (flush || has_room) state_nx = FS_FETCH;
            FS_FETCH:   if (flush && !mem_ack) state_nx = FS_DISCARD;
                        else if (flush)        state_nx = FS_FETCH;
                        else if (mem_ack)      state_nx = FS_IDLE;
            FS_DISCARD: if (mem_ack)           state_nx = FS_FETCH;
            default:    state_nx = FS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr  <= RESET_ADDR & ~LOW_MASK;
            cur_skip  <= (BUS_BYTES == 2) && RESET_ADDR[0];
            pend_addr <= '0;
            pend_skip <= 1'b0;
        end else begin
            unique case (state)
                FS_IDLE: if (flush) begin
                    cur_addr <= tgt_addr;
                    cur_skip <= tgt_skip;
                end
                FS_FETCH: if (flush && !mem_ack) begin
                    pend_addr <= tgt_addr;
                    pend_skip <= tgt_skip;
                end else if (flush) begin
                    cur_addr <= tgt_addr;
                    cur_skip <= tgt_skip;
                end else if (mem_ack) begin
                    cur_addr <= cur_addr + STEP;
                    cur_skip <= 1'b0;
                end
                FS_DISCARD: if (flush && mem_ack) begin
                    cur_addr <= tgt_addr;
                    cur_skip <= tgt_skip;
                end else if (flush) begin
                    pend_addr <= tgt_addr;
                    pend_skip <= tgt_skip;
                end else if (mem_ack) begin
                    cur_addr <= pend_addr;
                    cur_skip <= pend_skip;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        mem_req  = (state != FS_IDLE);
        mem_addr = cur_addr;
        take     = (state == FS_FETCH) && mem_ack && !flush;
        skip_low = cur_skip;
    end

    // R2: request and address held until acknowledged
    a_r2_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    // R4: bus addresses are aligned to the bus width
    a_r4_aligned_addr: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> ((mem_addr & LOW_MASK) == '0));
endmodule

// File: rtl/prefetch_queue.sv
module prefetch_queue #(
    parameter int                BUS_BYTES  = 2,
    parameter int                ADDR_W     = 20,
    parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   flush,
    input  logic [ADDR_W-1:0]      flush_addr,
    output logic                   mem_req,
    output logic [ADDR_W-1:0]      mem_addr,
    input  logic                   mem_ack,
    input  logic [8*BUS_BYTES-1:0] mem_rdata,
    output logic                   byte_valid,
    output logic [7:0]             byte_data,
    input  logic                   pop
);
    localparam int DEPTH = (BUS_BYTES == 2) ? 6 : 4;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [CNT_W-1:0]       level;
    logic                   take, skip_low;
    logic [8*BUS_BYTES-1:0] lane_data;
    logic [1:0]             lane_cnt;

    generate
        if (BUS_BYTES == 2) begin : g_wide
            assign lane_data = skip_low ? {8'h00, mem_rdata[15:8]} : mem_rdata;
            assign lane_cnt  = skip_low ? 2'd1 : 2'd2;
        end else begin : g_narrow
            assign lane_data = mem_rdata;
            assign lane_cnt  = skip_low ? 2'd0 : 2'd1;
        end
    endgenerate

    pq_fetch_ctl #(
        .BUS_BYTES (BUS_BYTES),
        .ADDR_W    (ADDR_W),
        .DEPTH     (DEPTH),
        .CNT_W     (CNT_W),
        .RESET_ADDR(RESET_ADDR)
    ) u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .flush_addr(flush_addr),
        .mem_ack   (mem_ack),
        .level     (level),
        .mem_req   (mem_req),
        .mem_addr  (mem_addr),
        .take      (take),
        .skip_low  (skip_low)
    );

    pq_store #(
        .DEPTH(DEPTH),
        .LANES(BUS_BYTES),
        .CNT_W(CNT_W)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (flush),
        .push     (take),
        .push_cnt (lane_cnt),
        .push_data(lane_data),
        .pop      (pop),
        .level    (level),
        .head     (byte_data),
        .valid    (byte_valid)
    );

    // R3: a read begins only with room for a whole word
    a_r3_room_on_issue: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req) |-> ((DEPTH - int'(level)) >= BUS_BYTES));

    // R7: a flush leaves the queue empty in the next cycle
    a_r7_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !byte_valid);
endmodule

// File: tb/test_prefetch_queue.sv
`timescale 1ns/1ps
module test_prefetch_queue;
    localparam int AW = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          flush = 1'b0;
    logic [AW-1:0] flush_addr = '0;
    logic          mem_req;
    logic [AW-1:0] mem_addr;
    logic          mem_ack = 1'b0;
    logic [15:0]   mem_rdata = '0;
    logic          byte_valid;
    logic [7:0]    byte_data;
    logic          pop = 1'b0;

    int n_chk = 0;
    int n_bad = 0;
    int lat = 1;
    int wcnt = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    prefetch_queue #(.BUS_BYTES(2), .ADDR_W(AW)) i_prefetch_queue (
        .clk(clk), .rst_n(rst_n), .flush(flush), .flush_addr(flush_addr),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .byte_valid(byte_valid), .byte_data(byte_data),
        .pop(pop)
    );

    function automatic logic [7:0] memb(input logic [AW-1:0] a);
        return a[7:0] ^ {a[3:0], a[11:8]} ^ 8'h3C;
    endfunction

    // memory model: acknowledges after lat waiting cycles, one-cycle ack
    always @(negedge clk) begin
        if (mem_ack) begin
            mem_ack = 1'b0;
            wcnt = 0;
        end else if (mem_req) begin
            if (wcnt >= lat) begin
                mem_ack = 1'b1;
                mem_rdata = {memb(mem_addr + AW'(1)), memb(mem_addr)};
            end else wcnt++;
        end else wcnt = 0;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pop_expect(input int n, input logic [AW-1:0] start, input string req);
        logic [AW-1:0] a = start;
        int left = n;
        int guard = 0;
        while (left > 0 && guard < 2000) begin
            @(negedge clk);
            guard++;
            if (byte_valid) begin
                chk(byte_data == memb(a), req, byte_data, memb(a));
                a++;
                left--;
                pop = 1'b1;
            end else pop = 1'b0;
        end
        chk(left == 0, req, left, 0);
        @(negedge clk);
        pop = 1'b0;
    endtask

    task automatic do_flush(input logic [AW-1:0] t);
        @(negedge clk);
        flush = 1'b1;
        flush_addr = t;
        @(negedge clk);
        flush = 1'b0;
        chk(!byte_valid, "R7 empty after flush", byte_valid, 0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!byte_valid, "R12 valid low after reset", byte_valid, 0);
        chk(mem_req && mem_addr == '0, "R12 first read at reset address", mem_addr, 0);
    endtask

    task automatic t_fill();
        lat = 1;
        idle(40);
        chk(!mem_req, "R1/R3 no request when full", mem_req, 0);
        lat = 20;
        for (int i = 0; i < 6; i++) begin
            chk(byte_valid && byte_data == memb(AW'(i)), "R1 six queued bytes", byte_data, memb(AW'(i)));
            pop = 1'b1;
            @(negedge clk);
        end
        pop = 1'b0;
        chk(!byte_valid, "R1 capacity exactly six", byte_valid, 0);
    endtask

    task automatic t_stream();
        lat = 0;
        pop_expect(20, AW'(6), "R5/R11 ordered stream while popping");
    endtask

    task automatic t_empty_pop();
        lat = 8;
        do_flush(AW'('h300));
        pop = 1'b1;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk(!byte_valid, "R6 valid low while empty", byte_valid, 0);
        end
        pop = 1'b0;
        pop_expect(4, AW'('h300), "R6 pop while empty ignored");
    endtask

    task automatic t_odd();
        lat = 2;
        do_flush(AW'('h101));
        pop_expect(9, AW'('h101), "R8 odd target upper byte first");
    endtask

    task automatic t_inflight();
        lat = 0;
        idle(40);
        lat = 6;
        @(negedge clk);
        flush = 1'b1;
        flush_addr = AW'('h40);
        @(negedge clk);
        flush_addr = AW'('h80);
        @(negedge clk);
        flush = 1'b0;
        chk(mem_req && mem_addr == AW'('h40), "R9/R2 outstanding read kept", mem_addr, 'h40);
        pop_expect(8, AW'('h80), "R9 discarded data not queued");
    endtask

    task automatic t_flush_pop();
        lat = 0;
        idle(40);
        @(negedge clk);
        pop = 1'b1;
        flush = 1'b1;
        flush_addr = AW'('h200);
        @(negedge clk);
        pop = 1'b0;
        flush = 1'b0;
        chk(!byte_valid, "R10 flush beats pop", byte_valid, 0);
        pop_expect(8, AW'('h200), "R10/R4 target stream after flush");
    endtask

    initial begin
        t_reset();
        t_fill();
        t_stream();
        t_empty_pop();
        t_odd();
        t_inflight();
        t_flush_pop();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule